// File: doc/BRIEF.md
# Interrupt Map and Gating Controller

This block holds the enable state for two banks of interrupt-map registers and uses it to gate level interrupts onto 48 interrupt-vector outputs. The first bank has eight registers, each governing a group of four consecutive PCI interrupt lines (lines 0 to 31). The second bank has sixteen registers, one per on-board I/O line (lines 32 to 47). An output follows its input level while the governing enable is set and is held low while it is clear. The gate is combinational, so a change of enable shows at the outputs in the same cycle as the register update, without waiting for an edge on the input.

Software reaches the map registers through a single-cycle 32-bit port with address, write enable and write data. Read data is registered. Each register sits in the upper word of an 8-byte slot. Only the enable bit (bit 31) can be written. The remaining bits are fixed: a seed pattern in the PCI bank and zero in the on-board bank. Apart from the power-on reset there is a device reset, which drops every PCI enable and keeps the on-board enables as they are.

The block also provides combinational line numbering. From a device/function number and an interrupt pin number it gives the input index used on the primary bus and the index used behind a secondary bridge.

Top module: `irq_map_gate`

## Requirements
- R1: After power-on reset (`rstN` low), PCI map register i reads `0x7C0 | (i << 2)` with bit 31 clear, every on-board map register reads zero, every `irqOut` bit is low and `rdData` is zero.
- R2: A write to a map register changes only bit 31, taking `regWdata[31]`. Bits 30..0 read back unchanged. With no write and no device reset, no enable changes.
- R3: A map register is reached only when address bit 2 is set. An access with address bit 2 clear reads zero and a write to it changes nothing.
- R4: PCI line n (0..31) drives `irqOut[n]` as `irqIn[n]` AND the enable of PCI map register n >> 2.
- R5: On-board line n (32..47) drives `irqOut[n]` as `irqIn[n]` AND the enable of on-board map register n - 32.
- R6: An output is never high while its input is low. A change of enable reaches `irqOut` right after the clock edge that writes it, with the inputs held steady.
- R7: A one-cycle `devRst` pulse clears all eight PCI enables and leaves the on-board enables and all stored low bits unchanged. If `devRst` and a PCI write fall in the same cycle, the clear wins.
- R8: `rdData` is registered. It shows the register addressed in the previous cycle and does not change between clock edges. Addresses outside both banks read zero, and writes to them have no effect.
- R9: Primary-bus line index `primLine` equals `pinNum` plus 16 when `devfn[0]` is set, and `pinNum` otherwise.
- R10: Bridge line index `bridgeLine` equals `(devfn[4:3] << 2) + pinNum`.
- R11: PCI map register k sits at byte offset `0xC04 + 8*k` (window 0xC00-0xC3F, index = address bits 5..3). On-board map register k sits at `0x1004 + 8*k` (window 0x1000-0x107F, index = address bits 6..3). Address bits 1..0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| devRst | input | 1 | Synchronous device reset; clears PCI enables only |
| regAddr | input | 16 | Register byte address |
| regWe | input | 1 | Write strobe for the addressed register |
| regWdata | input | 32 | Write data; only bit 31 is stored |
| rdData | output | 32 | Registered read data for the previous cycle's address |
| irqIn | input | 48 | Incoming interrupt levels (0..31 PCI, 32..47 on-board) |
| irqOut | output | 48 | Gated interrupt-vector outputs |
| devfn | input | 8 | Device/function number for line numbering |
| pinNum | input | 2 | Interrupt pin number (0..3) |
| primLine | output | 6 | Primary-bus line index |
| bridgeLine | output | 6 | Secondary-bridge line index |

## Verification
The only state in this block is one enable flop per map register. A wrong enable appears on `irqOut` as soon as the register updates: a group of four PCI outputs, or a single on-board output, either stays low against a high input or passes a level it should block. The same error appears in bit 31 of `rdData` one cycle after the register is addressed. A decode fault that sends a write to the wrong register therefore shows on the outputs of the wrong group. A decode fault that skips the bit-2 check shows up as nonzero read data from a lower word.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

  localparam int ADDR_W        = 16;
  localparam int DATA_W        = 32;
  localparam int PCI_MAPS      = 8;
  localparam int LINES_PER_MAP = 4;
  localparam int OBIO_MAPS     = 16;
  localparam int PCI_LINES     = PCI_MAPS * LINES_PER_MAP;
  localparam int IRQ_LINES     = PCI_LINES + OBIO_MAPS;
  localparam int PSEL_W        = $clog2(PCI_MAPS);
  localparam int OSEL_W        = $clog2(OBIO_MAPS);
  localparam int IDX_W         = (PSEL_W > OSEL_W) ? PSEL_W : OSEL_W;
  localparam int LINE_W        = $clog2(IRQ_LINES);
  localparam int DEVFN_W       = 8;
  localparam int PIN_W         = 2;

  localparam logic [ADDR_W-1:0] PCI_BASE  = 16'h0C00;
  localparam logic [ADDR_W-1:0] OBIO_BASE = 16'h1000;
  localparam logic [10:0]       SEED_HI   = 11'h7C0;

  // Strobes handed from the address decoder to the register bank.
  typedef struct packed {
    logic             wrPci;
    logic             wrObio;
    logic             rdPci;
    logic             rdObio;
    logic [IDX_W-1:0] idx;
    logic             enVal;
  } mapStrobe_t;

  // Fixed low field of PCI map register sel.
  function automatic logic [DATA_W-2:0] pciMapSeed(input logic [PSEL_W-1:0] sel);
    return (DATA_W-1)'(SEED_HI) | (DATA_W-1)'({sel, 2'b00});
  endfunction

endpackage

// File: rtl/irqmap_decode.sv
module irqmap_decode
  import irqmap_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W,
  parameter int PCI_REGS  = PCI_MAPS,
  parameter int OBIO_REGS = OBIO_MAPS
) (
  input  logic [ADDR_BITS-1:0] regAddr,
  input  logic                 regWe,
  input  logic                 wrMsb,
  output mapStrobe_t           strobe
);

  localparam int PCI_LOG  = $clog2(PCI_REGS) + 3;
  localparam int OBIO_LOG = $clog2(OBIO_REGS) + 3;

  logic pciHit;
  logic obioHit;
  logic upperWord;
  logic unusedLow;

  assign unusedLow = ^regAddr[1:0];
  assign upperWord = regAddr[2];
  assign pciHit    = (regAddr[ADDR_BITS-1:PCI_LOG]  == PCI_BASE[ADDR_BITS-1:PCI_LOG]);
  assign obioHit   = (regAddr[ADDR_BITS-1:OBIO_LOG] == OBIO_BASE[ADDR_BITS-1:OBIO_LOG]);

  always_comb begin
    strobe        = '0;
    strobe.rdPci  = pciHit & upperWord;
    strobe.rdObio = obioHit & upperWord;
    strobe.wrPci  = regWe & pciHit & upperWord;
    strobe.wrObio = regWe & obioHit & upperWord;
    strobe.enVal  = wrMsb;
    if (pciHit) strobe.idx = IDX_W'(regAddr[PCI_LOG-1:3]);
    else        strobe.idx = IDX_W'(regAddr[OBIO_LOG-1:3]);
  end

endmodule

// File: rtl/irqmap_bank.sv
module irqmap_bank
  import irqmap_pkg::*;
#(
  parameter int PCI_REGS  = PCI_MAPS,
  parameter int OBIO_REGS = OBIO_MAPS,
  parameter int WORD_W    = DATA_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 devRst,
  input  mapStrobe_t           strobe,
  output logic [PCI_REGS-1:0]  pciEn,
  output logic [OBIO_REGS-1:0] obioEn,
  output logic [WORD_W-1:0]    rdData
);

  localparam int PS_W = $clog2(PCI_REGS);
  localparam int OS_W = $clog2(OBIO_REGS);

  logic [PS_W-1:0]   pSel;
  logic [OS_W-1:0]   oSel;
  logic [WORD_W-1:0] rdNext;

  assign pSel = strobe.idx[PS_W-1:0];
  assign oSel = strobe.idx[OS_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pciEn <= '0;
    end else if (devRst) begin
      pciEn <= '0;
    end else if (strobe.wrPci) begin
      pciEn[pSel] <= strobe.enVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      obioEn <= '0;
    end else if (strobe.wrObio) begin
      obioEn[oSel] <= strobe.enVal;
    end
  end

  always_comb begin
    if (strobe.rdPci)       rdNext = {pciEn[pSel], pciMapSeed(pSel)};
    else if (strobe.rdObio) rdNext = {obioEn[oSel], {(WORD_W-1){1'b0}}};
    else                    rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

endmodule

// File: rtl/irqmap_gate.sv
module irqmap_gate
  import irqmap_pkg::*;
#(
  parameter int PCI_REGS  = PCI_MAPS,
  parameter int GROUP     = LINES_PER_MAP,
  parameter int OBIO_REGS = OBIO_MAPS
) (
  input  logic [PCI_REGS-1:0]                  pciEn,
  input  logic [OBIO_REGS-1:0]                 obioEn,
  input  logic [PCI_REGS*GROUP+OBIO_REGS-1:0]  irqIn,
  output logic [PCI_REGS*GROUP+OBIO_REGS-1:0]  irqOut
);

  localparam int NPCI = PCI_REGS * GROUP;

  for (genvar n = 0; n < NPCI; n++) begin : g_pci
    assign irqOut[n] = irqIn[n] & pciEn[n / GROUP];
  end

  for (genvar m = 0; m < OBIO_REGS; m++) begin : g_obio
    assign irqOut[NPCI + m] = irqIn[NPCI + m] & obioEn[m];
  end

endmodule

// File: rtl/irqmap_linenum.sv
module irqmap_linenum
  import irqmap_pkg::*;
#(
  parameter int DF_W = DEVFN_W,
  parameter int PN_W = PIN_W,
  parameter int LN_W = LINE_W
) (
  input  logic [DF_W-1:0] devfn,
  input  logic [PN_W-1:0] pinNum,
  output logic [LN_W-1:0] primLine,
  output logic [LN_W-1:0] bridgeLine
);

  localparam logic [LN_W-1:0] FUNC_OFS = LN_W'(16);

  logic unusedDf;
  assign unusedDf = ^{devfn[DF_W-1:5], devfn[2:1]};

  assign primLine   = LN_W'(pinNum) + (devfn[0] ? FUNC_OFS : '0);
  assign bridgeLine = LN_W'({devfn[4:3], 2'b00}) + LN_W'(pinNum);

endmodule

// File: rtl/irq_map_gate.sv
module irq_map_gate
  import irqmap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 devRst,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWe,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    rdData,
  input  logic [IRQ_LINES-1:0] irqIn,
  output logic [IRQ_LINES-1:0] irqOut,
  input  logic [DEVFN_W-1:0]   devfn,
  input  logic [PIN_W-1:0]     pinNum,
  output logic [LINE_W-1:0]    primLine,
  output logic [LINE_W-1:0]    bridgeLine
);

  mapStrobe_t           strobe;
  logic [PCI_MAPS-1:0]  pciEn;
  logic [OBIO_MAPS-1:0] obioEn;
  logic                 unusedWd;

  assign unusedWd = ^regWdata[DATA_W-2:0];

  irqmap_decode u_decode (
    .regAddr (regAddr),
    .regWe   (regWe),
    .wrMsb   (regWdata[DATA_W-1]),
    .strobe  (strobe)
  );

  irqmap_bank u_bank (
    .clk    (clk),
    .rstN   (rstN),
    .devRst (devRst),
    .strobe (strobe),
    .pciEn  (pciEn),
    .obioEn (obioEn),
    .rdData (rdData)
  );

  irqmap_gate u_gate (
    .pciEn  (pciEn),
    .obioEn (obioEn),
    .irqIn  (irqIn),
    .irqOut (irqOut)
  );

  irqmap_linenum u_linenum (
    .devfn      (devfn),
    .pinNum     (pinNum),
    .primLine   (primLine),
    .bridgeLine (bridgeLine)
  );

endmodule

// File: rtl/irq_map_gate_chk.sv
module irq_map_gate_chk
  import irqmap_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 devRst,
  input logic [ADDR_W-1:0]    regAddr,
  input logic                 regWe,
  input logic [DATA_W-1:0]    rdData,
  input logic [IRQ_LINES-1:0] irqIn,
  input logic [IRQ_LINES-1:0] irqOut,
  input logic [PCI_MAPS-1:0]  pciEn,
  input logic [OBIO_MAPS-1:0] obioEn,
  input logic [DEVFN_W-1:0]   devfn,
  input logic [PIN_W-1:0]     pinNum,
  input logic [LINE_W-1:0]    primLine,
  input logic [LINE_W-1:0]    bridgeLine
);

  assert_no_ghost_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((irqOut & ~irqIn) == '0));

  assert_pci_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    devRst |=> (irqOut[PCI_LINES-1:0] == '0));

  assert_obio_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (devRst && !regWe) |=> $stable(obioEn));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!regWe && !devRst) |=> ($stable(pciEn) && $stable(obioEn)));

  assert_single_bit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !devRst) |=> ($countones({pciEn, obioEn} ^ $past({pciEn, obioEn})) <= 1));

  assert_low_slot_R3: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr[2] |=> (rdData == '0));

  assert_bridge_pin_R10: assert property (@(posedge clk) disable iff (!rstN)
    (bridgeLine[1:0] == pinNum));

  assert_prim_even_R9: assert property (@(posedge clk) disable iff (!rstN)
    !devfn[0] |-> (primLine == LINE_W'(pinNum)));

endmodule

bind irq_map_gate irq_map_gate_chk u_chk (.*);

// File: tb/irq_map_gate_tb.sv
`timescale 1ns/100ps
module irq_map_gate_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        devRst = 1'b0;
  logic [15:0] regAddr = 16'h0C04;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] rdData;
  logic [47:0] irqIn = '1;
  logic [47:0] irqOut;
  logic [7:0]  devfn = '0;
  logic [1:0]  pinNum = '0;
  logic [5:0]  primLine;
  logic [5:0]  bridgeLine;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_map_gate u_dut (
    .clk(clk), .rstN(rstN), .devRst(devRst), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .rdData(rdData), .irqIn(irqIn), .irqOut(irqOut),
    .devfn(devfn), .pinNum(pinNum), .primLine(primLine), .bridgeLine(bridgeLine)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [31:0] expRd;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{4'd1,  1'b0, 16'h0C04, 32'h0,        32'h0000_07C0}, // R1 seed reg0
    '{4'd1,  1'b0, 16'h0C3C, 32'h0,        32'h0000_07DC}, // R1 seed reg7
    '{4'd1,  1'b0, 16'h1004, 32'h0,        32'h0},         // R1 on-board zero
    '{4'd3,  1'b0, 16'h0C00, 32'h0,        32'h0},         // R3 lower word
    '{4'd2,  1'b1, 16'h0C0C, 32'hFFFF_FFFF, 32'h0},        // R2 set reg1
    '{4'd2,  1'b0, 16'h0C0C, 32'h0,        32'h8000_07C4}, // R2 low bits kept
    '{4'd3,  1'b1, 16'h0C10, 32'h8000_0000, 32'h0},        // R3 ignored write
    '{4'd3,  1'b0, 16'h0C14, 32'h0,        32'h0000_07C8}, // R3 reg2 unchanged
    '{4'd11, 1'b1, 16'h1014, 32'h8000_0000, 32'h0},        // R11 on-board reg2
    '{4'd11, 1'b0, 16'h1014, 32'h0,        32'h8000_0000}, // R11 read back
    '{4'd2,  1'b1, 16'h1014, 32'h7FFF_FFFF, 32'h0},        // R2 clear enable
    '{4'd2,  1'b0, 16'h1014, 32'h0,        32'h0},         // R2 low bits stay 0
    '{4'd8,  1'b1, 16'h2000, 32'hFFFF_FFFF, 32'h0},        // R8 unmapped write
    '{4'd8,  1'b0, 16'h2000, 32'h0,        32'h0},         // R8 unmapped read
    '{4'd8,  1'b0, 16'h1084, 32'h0,        32'h0}          // R8 past window
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    tick();
    regWe = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [15:0] a, input logic [31:0] exp);
    regAddr = a;
    tick();
    check(req, 64'(rdData), 64'(exp));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", 64'(irqOut), 64'h0);
    check("R1", 64'(rdData), 64'h0);
    rstN = 1'b1;
    tick();
    check("R1", 64'(irqOut), 64'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].we) wr(VECS[i].addr, VECS[i].wdata);
      else rdCheck($sformatf("R%0d", VECS[i].req), VECS[i].addr, VECS[i].expRd);
    end

    // R4 PCI gating: only reg1 (lines 4..7) enabled
    irqIn = '1; #1;
    check("R4", 64'(irqOut), 64'h0000_0000_00F0);
    irqIn = 48'hAAAA_AAAA_AAAA; #1;
    check("R4", 64'(irqOut), 64'h0000_0000_00A0);

    // R5 on-board gating: reg5 -> line 37
    irqIn = '1;
    wr(16'h102C, 32'h8000_0000);
    check("R5", 64'(irqOut), 64'h0020_0000_00F0);
    irqIn = 48'h0000_FFFF_FFFF; #1;
    check("R5", 64'(irqOut), 64'h0000_0000_00F0);
    irqIn = '1;

    // R6 enable change reaches outputs with inputs steady
    wr(16'h0C0C, 32'h0);
    check("R6", 64'(irqOut), 64'h0020_0000_0000);
    wr(16'h0C3C, 32'h8000_0000);
    check("R6", 64'(irqOut), 64'h0020_F000_0000);

    // R7 device reset: PCI cleared, on-board kept; clear beats same-cycle write
    wr(16'h0C04, 32'h8000_0000);
    devRst = 1'b1;
    wr(16'h0C14, 32'h8000_0000);
    devRst = 1'b0;
    check("R7", 64'(irqOut), 64'h0020_0000_0000);
    rdCheck("R7", 16'h0C3C, 32'h0000_07DC);
    rdCheck("R7", 16'h0C14, 32'h0000_07C8);
    rdCheck("R7", 16'h102C, 32'h8000_0000);

    // R8 read data holds between edges
    regAddr = 16'h0C04; #1;
    check("R8", 64'(rdData), 64'h8000_0000);
    tick();
    check("R8", 64'(rdData), 64'h0000_07C0);

    // R9 / R10 line numbering
    for (int d = 0; d < 32; d += 3) begin
      for (int p = 0; p < 4; p++) begin
        devfn = 8'(d * 5); pinNum = 2'(p); #1;
        check("R9", 64'(primLine), 64'(p + (devfn[0] ? 16 : 0)));
        check("R10", 64'(bridgeLine), 64'(((d * 5) & 8'h18) / 2 + p));
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule